// File: doc/BRIEF.md
# Two-Cycle Direct-Form-I Biquad Section

This block is one second-order recursive filter section in direct form I. It takes a wide signed sample over a valid/ready input and computes y[n] = x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. The leading feedforward weight is fixed at unity, and the overall level is set by a separate output gain. Every accepted sample takes exactly two clock cycles. In the first cycle the block forms the feedforward products and the partial sum, and shifts the input history. In the second cycle it subtracts the feedback products, shifts the output history and registers the scaled, saturated result together with its valid pulse.

The input is widened and moved left by a fixed pre-shift before filtering. The output scaling moves it back right by the same amount. All weights are signed fixed-point values with FRAC fractional bits: Q2.30 by default, so 1.0 is 0x4000_0000. Each product is floored (arithmetic shift right by FRAC) straight after its multiply. The weights and the gain are plain inputs and must be held steady while a sample is in flight.

On the input side, a transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the cycle after each transfer. A producer that raises `in_valid` during that cycle is not served and must hold its sample until `in_ready` returns. The output has no back-pressure: the consumer must take `out_data` in the cycle `out_valid` is high.

Top module: `biquad_df1`

## Requirements
- R1: The recursion is y[n] = x'[n] + fl(b1·x'[n-1]) + fl(b2·x'[n-2]) − fl(a1·y[n-1]) − fl(a2·y[n-2]). Here fl(p) is p shifted arithmetically right by FRAC (floor), the weights are signed CW-bit values with FRAC fractional bits, and b0 is fixed at 1.0.
- R2: The working input is x'[n] = in_data shifted left by PRE bits (12 by default), sign-extended. The output is the floor of y[n]·gain shifted right by FRAC+PRE, where gain is signed Q2.FRAC.
- R3: For a transfer on edge k, `in_ready` is low in the cycle after edge k. `out_valid` is high, and `out_data` holds the new result, only in the cycle after edge k+1.
- R4: `in_ready` is high again in the cycle where `out_valid` is high, so samples can be taken every second cycle.
- R5: `in_valid` or `in_data` activity while `in_ready` is low changes neither the history nor the outputs.
- R6: The feedback terms use y[n-1] and y[n-2] exactly, with no extra sample of delay.
- R7: The output is clamped to the signed OW-bit range (48 bits by default) rather than wrapped.
- R8: y[n] is clamped to the signed YW-bit history range (PRE+DW+4 = 64 bits by default) before it is stored and scaled.
- R9: A synchronous reset clears all history, `out_data` and `out_valid`, and leaves `in_ready` high.
- R10: `out_data` holds its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW (48) | Signed input sample |
| coef_b1 | input | CW (32) | Feedforward weight for x[n-1], signed Q2.FRAC |
| coef_b2 | input | CW (32) | Feedforward weight for x[n-2], signed Q2.FRAC |
| coef_a1 | input | CW (32) | Feedback weight for y[n-1], signed Q2.FRAC |
| coef_a2 | input | CW (32) | Feedback weight for y[n-2], signed Q2.FRAC |
| out_gain | input | CW (32) | Output gain, signed Q2.FRAC |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OW (48) | Saturated signed output sample |

## Verification
Two things can fall in one cycle. The cycle that registers a result and raises `out_valid` is also the first cycle in which `in_ready` is high again, so the next sample can transfer on the very edge after the result appears. The bench provokes this with back-to-back transfers and with a producer that holds `in_valid` through the busy cycle while changing the data. It judges the outcome by comparing every result against a wide-integer model of the recursion, which must match even though the second producer value was never taken.

// File: rtl/biq_pkg.sv
package biq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FB   = 1'b1
  } biq_state_e;
endpackage

// File: rtl/biq_mulshift.sv
// Signed multiply followed at once by a flooring shift right.
module biq_mulshift #(
  parameter int AW = 60,
  parameter int BW = 32,
  parameter int SH = 30,
  localparam int PW = AW + BW,
  localparam int OW = PW - SH
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic signed [OW-1:0] p
);
  logic signed [PW-1:0] full;
  assign full = a * b;
  assign p    = OW'(full >>> SH);
endmodule

// File: rtl/biq_sat.sv
// Clamp a signed value into a narrower signed range.
module biq_sat #(
  parameter int IW = 69,
  parameter int OW = 64
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  generate
    if (IW > OW) begin : g_clamp
      localparam logic signed [IW-1:0] MAXV = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
      localparam logic signed [IW-1:0] MINV = ~MAXV;
      always_comb begin
        if (din > MAXV)      dout = MAXV[OW-1:0];
        else if (din < MINV) dout = MINV[OW-1:0];
        else                 dout = din[OW-1:0];
      end
    end else begin : g_pass
      assign dout = OW'(din);
    end
  endgenerate
endmodule

// File: rtl/biquad_df1.sv
module biquad_df1
  import biq_pkg::*;
#(
  parameter int DW    = 48,
  parameter int OW    = 48,
  parameter int CW    = 32,
  parameter int FRAC  = 30,
  parameter int PRE   = 12,
  parameter int GUARD = 4,
  parameter int TAPS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic signed [CW-1:0] coef_b1,
  input  logic signed [CW-1:0] coef_b2,
  input  logic signed [CW-1:0] coef_a1,
  input  logic signed [CW-1:0] coef_a2,
  input  logic signed [CW-1:0] out_gain,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int XW  = DW + PRE;
  localparam int YW  = XW + GUARD;
  localparam int PXW = XW + CW - FRAC;
  localparam int PYW = YW + CW - FRAC;
  localparam int AW  = PYW + 3;
  localparam int GW  = YW + CW - FRAC - PRE;

  biq_state_e st;
  logic take;

  logic signed [XW-1:0]  x_cur;
  logic signed [XW-1:0]  xh   [TAPS];
  logic signed [YW-1:0]  yh   [TAPS];
  logic signed [CW-1:0]  bc   [TAPS];
  logic signed [CW-1:0]  ac   [TAPS];
  logic signed [PXW-1:0] pb   [TAPS];
  logic signed [PYW-1:0] pa   [TAPS];
  logic signed [AW-1:0]  ff_sum, acc, y_full;
  logic signed [YW-1:0]  y_sat;
  logic signed [GW-1:0]  y_scaled;
  logic signed [OW-1:0]  y_out;

  assign in_ready = (st == ST_IDLE);
  assign take     = in_valid && in_ready;
  assign x_cur    = XW'(in_data) <<< PRE;

  assign bc[0] = coef_b1;
  assign bc[1] = coef_b2;
  assign ac[0] = coef_a1;
  assign ac[1] = coef_a2;

  // One product pair per history tap, each renormalised after its multiply.
  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      biq_mulshift #(.AW(XW), .BW(CW), .SH(FRAC)) u_ff (
        .a(xh[k]), .b(bc[k]), .p(pb[k])
      );
      biq_mulshift #(.AW(YW), .BW(CW), .SH(FRAC)) u_fb (
        .a(yh[k]), .b(ac[k]), .p(pa[k])
      );
    end
  endgenerate

  // First cycle: unity b0 term plus floored feedforward products.
  assign ff_sum = AW'(x_cur) + AW'(pb[0]) + AW'(pb[1]);
  // Second cycle: feedback products use the history as it stood before this edge.
  assign y_full = acc - AW'(pa[0]) - AW'(pa[1]);

  biq_sat #(.IW(AW), .OW(YW)) u_ysat (.din(y_full), .dout(y_sat));

  biq_mulshift #(.AW(YW), .BW(CW), .SH(FRAC + PRE)) u_gain (
    .a(y_sat), .b(out_gain), .p(y_scaled)
  );

  biq_sat #(.IW(GW), .OW(OW)) u_osat (.din(y_scaled), .dout(y_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < TAPS; k++) begin
        xh[k] <= '0;
        yh[k] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take) begin
            acc   <= ff_sum;
            xh[0] <= x_cur;
            xh[1] <= xh[0];
            st    <= ST_FB;
          end
        end
        ST_FB: begin
          yh[0]     <= y_sat;
          yh[1]     <= yh[0];
          out_data  <= y_out;
          out_valid <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/biquad_df1_chk.sv
module biquad_df1_chk #(
  parameter int OW = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  // R3: busy in the cycle after a transfer
  a_r3_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R3: result appears exactly two edges after a transfer
  a_r3_result_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> ##2 out_valid);

  // R4: ready again whenever a result is presented
  a_r4_ready_with_result: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  // R3: a result always follows a busy cycle and is a single pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R10: output held while no result is flagged
  a_r10_hold_output: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data));
endmodule

bind biquad_df1 biquad_df1_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_biquad_df1.sv
module tb_biquad_df1;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 48, OW = 48, CW = 32, FRAC = 30, PRE = 12, YW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic signed [CW-1:0] b1 = '0, b2 = '0, a1 = '0, a2 = '0, gain = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  biquad_df1 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef_b1(b1), .coef_b2(b2), .coef_a1(a1),
    .coef_a2(a2), .out_gain(gain), .out_valid(out_valid), .out_data(out_data)
  );

  // Bench model state, wide integers
  logic signed [127:0] mx1, mx2, my1, my2;
  logic signed [127:0] last_exp;

  function automatic logic signed [127:0] sat(input logic signed [127:0] v, input int w);
    logic signed [127:0] hi, lo;
    hi = (128'sd1 <<< (w - 1)) - 128'sd1;
    lo = -(128'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // R1 R2 R6 R7 R8: model step; returns expected port value and advances history
  function automatic logic signed [127:0] model_step(input logic signed [DW-1:0] x);
    logic signed [127:0] xs, y, t, c;
    xs = 128'(x) <<< PRE;
    c = 128'(b1); t = (mx1 * c) >>> FRAC; y = xs + t;
    c = 128'(b2); t = (mx2 * c) >>> FRAC; y = y + t;
    c = 128'(a1); t = (my1 * c) >>> FRAC; y = y - t;
    c = 128'(a2); t = (my2 * c) >>> FRAC; y = y - t;
    y = sat(y, YW);
    mx2 = mx1; mx1 = xs;
    my2 = my1; my1 = y;
    c = 128'(gain);
    return sat((y * c) >>> (FRAC + PRE), OW);
  endfunction

  task automatic chk(input string req, input logic signed [127:0] act, input logic signed [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; last_exp = 0;
  endtask

  // Send one sample; optionally keep in_valid high with junk data during the busy cycle
  task automatic send(input logic signed [DW-1:0] x, input bit junk, input string req);
    logic signed [127:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    e = model_step(x);
    chk("R3 busy", 128'(in_ready), 128'(0));
    chk("R3 no early valid", 128'(out_valid), 128'(0));
    if (junk) begin
      in_data = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    end else begin
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 valid", 128'(out_valid), 128'(1));
    chk("R4 ready", 128'(in_ready), 128'(1));
    chk(req, 128'(out_data), e);
    last_exp = e;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  function automatic logic signed [CW-1:0] rnd_coef(input int unsigned span);
    return CW'($signed({1'b0, $urandom_range(0, 2 * span)}) - $signed({1'b0, span}));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    // R9: reset state (b1 nonzero beforehand, history must still start clear)
    b1 = 32'sh2000_0000; gain = 32'sh4000_0000;
    do_reset();
    @(negedge clk);
    chk("R9 in_ready", 128'(in_ready), 128'(1));
    chk("R9 out_valid", 128'(out_valid), 128'(0));
    chk("R9 out_data", 128'(out_data), 128'(0));

    // R1 R2: unity pass-through with zero weights, unity gain
    b1 = '0; b2 = '0; a1 = '0; a2 = '0; gain = 32'sh4000_0000;
    send(48'sd123456789, 1'b0, "R1 pass-through");
    send(-48'sd987654321, 1'b0, "R1 pass-through neg");
    chk("R2 unity value", 128'(out_data), -128'sd987654321);

    // R10: output holds between results
    repeat (4) @(negedge clk);
    chk("R10 hold", 128'(out_data), last_exp);

    // R9: history cleared by reset, first output ignores b1
    b1 = 32'sh4000_0000;
    send(48'sd1000, 1'b0, "R9 prime");
    do_reset();
    send(48'sd7, 1'b0, "R9 clear history");
    chk("R9 first out", 128'(out_data), 128'sd7);

    // R6: impulse response with feedback, y = x - 0.5 y[n-1] - 0.25 y[n-2]
    do_reset();
    b1 = '0; b2 = '0; a1 = 32'sh2000_0000; a2 = 32'sh1000_0000; gain = 32'sh4000_0000;
    send(48'sd1 <<< 40, 1'b0, "R6 impulse 0");
    for (int i = 1; i < 6; i++) send('0, 1'b0, "R6 impulse tail");

    // R5: valid and changing data during busy cycle are not taken
    do_reset();
    b1 = 32'sh1800_0000; b2 = -32'sh0800_0000; a1 = -32'sh1000_0000; a2 = 32'sh0400_0000;
    for (int i = 0; i < 8; i++) send(48'sd5000 * (i + 1), 1'b1, "R5 ignored while busy");

    // R7: output saturation both ways
    do_reset();
    b1 = '0; b2 = '0; a1 = '0; a2 = '0; gain = 32'sh7FFF_FFFF;
    send(48'sh7FFF_FFFF_FFFF, 1'b0, "R7 sat max");
    chk("R7 max value", 128'(out_data), (128'sd1 <<< 47) - 1);
    send(-48'sh8000_0000_0000, 1'b0, "R7 sat min");
    chk("R7 min value", 128'(out_data), -(128'sd1 <<< 47));

    // R8: history clamp with growing feedback (a1 = -2.0), small gain
    do_reset();
    a1 = 32'sh8000_0000; gain = 32'sh0010_0000;
    for (int i = 0; i < 8; i++) send(48'sh7FFF_FFFF_FFFF, 1'b0, "R8 history clamp");
    chk("R8 clamped level", 128'(out_data), ((128'sd1 <<< 63) - 1) * 128'sd1048576 >>> 42);

    // R1 R2 R3 R4: random weights and samples, random gaps
    for (int blk = 0; blk < 6; blk++) begin
      do_reset();
      b1 = rnd_coef(32'd1073741823); b2 = rnd_coef(32'd1073741823);
      a1 = rnd_coef(32'd429496729);  a2 = rnd_coef(32'd429496729);
      gain = CW'($urandom_range(0, 32'h7FFF_FFFF));
      for (int i = 0; i < 50; i++) begin
        if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
        send(DW'({$urandom, $urandom}), ($urandom_range(0, 1) == 1), "R1 random");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule